// File: doc/BRIEF.md
# Floating-Point Status Flag Transfer Unit

This block keeps two status registers side by side: an eight-flag floating-point status word and a five-bit CPU status word. A transfer command carries an eight-bit select mask. For each CPU status bit, the unit looks at the floating-point flags that feed it. If any of them is selected, the bit is rewritten as the OR of the selected sources. If none is selected, the bit keeps its value. The transfer takes one clock edge. It also clears any selected sticky overflow or underflow flag, so that conditional branches can test the result of a floating-point compare.

The arithmetic side writes the six plain flags through a load port. It raises the two sticky flags with event pulses. A pipeline hazard window opens when a two-cycle operation is issued and lasts `DELAY_SLOTS` cycles. A transfer strobe that lands inside the window is refused: the hazard pin pulses and neither register is touched. The transfer strobe is a plain control pin with no back-pressure. Every strobe is accepted in its own cycle, or refused through the hazard pin in that same cycle, and a refused transfer is not retried.

Top module: `fsx_flag_xfer`

## Requirements
- R1: A synchronous active-high `rst` clears `fp_status` and `cpu_status` to all zeros.
- R2: Mask and flag bit positions are TF=0, CI=1, ZI=2, ZF=3, NI=4, NF=5, LUF=6, LVF=7. On an accepted transfer with mask bit 6 or 7 set, CPU bit 4 (OV) becomes the OR of each selected LUF/LVF flag's current value.
- R3: On an accepted transfer, CPU bit 3 (N) becomes the OR of the selected NF/NI values whenever mask bit 4 or 5 is set. Likewise CPU bit 2 (Z) becomes the OR of the selected ZF/ZI values whenever mask bit 2 or 3 is set.
- R4: On an accepted transfer with mask bit 0 set, CPU bit 0 (C) and CPU bit 1 (TC) both take the current TF value.
- R5: A CPU bit with no selected source keeps its value. A mask selecting only CI changes no CPU bit, and with no strobe the CPU word is unchanged.
- R6: An accepted transfer clears `fp_status` bits 6 and 7 where the mask selects them and changes no other floating-point flag.
- R7: `unf_evt` sets bit 6 and `ovf_evt` sets bit 7. These bits hold until cleared by a transfer. When a set and a clear occur in the same cycle, the set wins.
- R8: A transfer strobed in one cycle shows its result on `cpu_status` and `fp_status` right after the next rising edge. It reads the flag values from before that edge.
- R9: During the `DELAY_SLOTS` cycles after a cycle with `op2_issue` high, a transfer strobe drives `hazard` high in that same cycle. The refused transfer modifies neither register.
- R10: `fp_upd_en` loads `fp_upd_val[5:0]` into flags 0 to 5 at the next edge. A transfer in that same cycle merges the flag values from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Transfer strobe |
| xfer_mask | input | 8 | Flag select mask |
| op2_issue | input | 1 | A two-cycle operation issues this cycle |
| fp_upd_en | input | 1 | Load enable for the six plain flags |
| fp_upd_val | input | 6 | New values for flags 0 to 5 |
| unf_evt | input | 1 | Underflow event, sets sticky flag 6 |
| ovf_evt | input | 1 | Overflow event, sets sticky flag 7 |
| fp_status | output | 8 | Floating-point status word |
| cpu_status | output | 5 | CPU status word {OV,N,Z,TC,C} |
| hazard | output | 1 | Strobe refused in a delay slot |

## Verification
The bench builds the unit with `DELAY_SLOTS` set to 2 rather than the default 1. With that value, a strobe in the second slot of the window must also be refused, and the first cycle after the window must be accepted. The same stimulus covers sticky set-versus-clear collisions, a load and a transfer in the same cycle, and masks that select only CI, a single flag of a pair, or all eight flags.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
  localparam int FP_W  = 8;
  localparam int CPU_W = 5;
  localparam int PLAIN_W = 6;

  // floating-point flag positions (also mask positions)
  localparam int F_TF  = 0;
  localparam int F_CI  = 1;
  localparam int F_ZI  = 2;
  localparam int F_ZF  = 3;
  localparam int F_NI  = 4;
  localparam int F_NF  = 5;
  localparam int F_LUF = 6;
  localparam int F_LVF = 7;

  // CPU status positions
  localparam int C_C  = 0;
  localparam int C_TC = 1;
  localparam int C_Z  = 2;
  localparam int C_N  = 3;
  localparam int C_OV = 4;

  typedef logic [FP_W-1:0]  fp_word_t;
  typedef logic [CPU_W-1:0] cpu_word_t;

  // which floating-point flags feed a given CPU bit
  function automatic fp_word_t src_of(input int dst);
    fp_word_t s;
    s = '0;
    case (dst)
      C_C:  s[F_TF] = 1'b1;
      C_TC: s[F_TF] = 1'b1;
      C_Z:  begin s[F_ZF] = 1'b1; s[F_ZI] = 1'b1; end
      C_N:  begin s[F_NF] = 1'b1; s[F_NI] = 1'b1; end
      C_OV: begin s[F_LVF] = 1'b1; s[F_LUF] = 1'b1; end
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/fsx_hazard.sv
module fsx_hazard #(
  parameter int DELAY_SLOTS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic op2_issue,
  input  logic xfer_req,
  output logic pending,
  output logic hazard,
  output logic fire
);
  localparam int CNT_W = $clog2(DELAY_SLOTS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY_SLOTS);

  logic [CNT_W-1:0] slots_left;

  always_ff @(posedge clk) begin
    if (rst)                 slots_left <= '0;
    else if (op2_issue)      slots_left <= LOAD;
    else if (slots_left != 0) slots_left <= slots_left - 1'b1;
  end

  assign pending = (slots_left != '0);
  assign hazard  = xfer_req & pending;
  assign fire    = xfer_req & ~pending;

  // R9
  issue_pend_chk: assert property (@(posedge clk) disable iff (rst)
    op2_issue |=> pending);
endmodule

// File: rtl/fsx_fp_flags.sv
module fsx_fp_flags
  import fsx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_en,
  input  logic [PLAIN_W-1:0] upd_val,
  input  logic               unf_evt,
  input  logic               ovf_evt,
  input  fp_word_t           clr_mask,
  output fp_word_t           flags
);
  logic [FP_W-1:PLAIN_W] set_vec;
  assign set_vec = {ovf_evt, unf_evt};

  for (genvar i = 0; i < FP_W; i++) begin : g_bit
    if (i < PLAIN_W) begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)         flags[i] <= 1'b0;
        else if (upd_en) flags[i] <= upd_val[i];
      end
    end else begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst)              flags[i] <= 1'b0;
        else if (set_vec[i])  flags[i] <= 1'b1;
        else if (clr_mask[i]) flags[i] <= 1'b0;
      end
    end
  end

  // R7
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> flags[F_LVF]);
  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[F_LUF] && !clr_mask[F_LUF]) |=> flags[F_LUF]);
  // R6
  plain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> flags[PLAIN_W-1:0] == $past(flags[PLAIN_W-1:0]));
endmodule

// File: rtl/fsx_merge.sv
module fsx_merge
  import fsx_pkg::*;
(
  input  fp_word_t  mask,
  input  fp_word_t  flags,
  input  cpu_word_t cur,
  output cpu_word_t nxt
);
  for (genvar d = 0; d < CPU_W; d++) begin : g_dst
    localparam fp_word_t SRC = src_of(d);
    logic picked;
    logic value;
    assign picked = |(mask & SRC);
    assign value  = |(mask & SRC & flags);
    assign nxt[d] = picked ? value : cur[d];
  end
endmodule

// File: rtl/fsx_flag_xfer.sv
module fsx_flag_xfer
  import fsx_pkg::*;
#(
  parameter int DELAY_SLOTS = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        xfer_req,
  input  logic [7:0]  xfer_mask,
  input  logic        op2_issue,
  input  logic        fp_upd_en,
  input  logic [5:0]  fp_upd_val,
  input  logic        unf_evt,
  input  logic        ovf_evt,
  output logic [7:0]  fp_status,
  output logic [4:0]  cpu_status,
  output logic        hazard
);
  logic      fire;
  logic      pending;
  fp_word_t  clr_mask;
  cpu_word_t cpu_nxt;
  cpu_word_t cpu_q;

  fsx_hazard #(.DELAY_SLOTS(DELAY_SLOTS)) u_haz (
    .clk(clk), .rst(rst), .op2_issue(op2_issue), .xfer_req(xfer_req),
    .pending(pending), .hazard(hazard), .fire(fire)
  );

  // only sticky flags are cleared by an accepted transfer
  always_comb begin
    clr_mask = '0;
    if (fire) begin
      clr_mask[F_LUF] = xfer_mask[F_LUF];
      clr_mask[F_LVF] = xfer_mask[F_LVF];
    end
  end

  fsx_fp_flags u_fp (
    .clk(clk), .rst(rst), .upd_en(fp_upd_en), .upd_val(fp_upd_val),
    .unf_evt(unf_evt), .ovf_evt(ovf_evt), .clr_mask(clr_mask),
    .flags(fp_status)
  );

  fsx_merge u_mrg (
    .mask(xfer_mask), .flags(fp_status), .cur(cpu_q), .nxt(cpu_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)       cpu_q <= '0;
    else if (fire) cpu_q <= cpu_nxt;
  end

  assign cpu_status = cpu_q;

  // R9
  haz_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    hazard |=> $stable(cpu_status));
  // R9
  haz_pend_chk: assert property (@(posedge clk) disable iff (rst)
    hazard |-> pending);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer_req |=> $stable(cpu_status));
  // R4
  tf_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && xfer_mask[F_TF]) |=> cpu_status[C_C] == cpu_status[C_TC]);
  // R6
  lvf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && xfer_mask[F_LVF] && !ovf_evt) |=> !fp_status[F_LVF]);
endmodule

// File: tb/sim_fsx_flag_xfer.sv
`timescale 1ns/1ps
module sim_fsx_flag_xfer;
  localparam int DS = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xfer_req = 1'b0;
  logic [7:0] xfer_mask = '0;
  logic       op2_issue = 1'b0;
  logic       fp_upd_en = 1'b0;
  logic [5:0] fp_upd_val = '0;
  logic       unf_evt = 1'b0;
  logic       ovf_evt = 1'b0;
  logic [7:0] fp_status;
  logic [4:0] cpu_status;
  logic       hazard;

  always #2 clk = ~clk;

  fsx_flag_xfer #(.DELAY_SLOTS(DS)) u0 (.*);

  typedef struct {
    logic [7:0] efp;
    logic [4:0] ecpu;
    logic       ehaz;
    logic       ahaz;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] mf = '0;
  logic [4:0] mc = '0;
  int pend = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic req, input logic [7:0] m, input logic op2,
                      input logic ue, input logic [5:0] uv, input logic un,
                      input logic ov, input string tag);
    item_t it;
    logic haz, fire;
    logic [7:0] nf;
    logic [4:0] nc;
    @(negedge clk);
    xfer_req = req; xfer_mask = m; op2_issue = op2;
    fp_upd_en = ue; fp_upd_val = uv; unf_evt = un; ovf_evt = ov;
    haz = req && (pend > 0);
    fire = req && !haz;
    nf = mf; nc = mc;
    if (fire) begin
      if (m[7] | m[6]) nc[4] = (m[7] & mf[7]) | (m[6] & mf[6]);   // R2
      if (m[5] | m[4]) nc[3] = (m[5] & mf[5]) | (m[4] & mf[4]);   // R3
      if (m[3] | m[2]) nc[2] = (m[3] & mf[3]) | (m[2] & mf[2]);   // R3
      if (m[0]) begin nc[0] = mf[0]; nc[1] = mf[0]; end          // R4
      if (m[6]) nf[6] = 1'b0;                                     // R6
      if (m[7]) nf[7] = 1'b0;
    end
    if (ue) nf[5:0] = uv;                                         // R10
    if (un) nf[6] = 1'b1;                                         // R7
    if (ov) nf[7] = 1'b1;
    pend = op2 ? DS : ((pend > 0) ? pend - 1 : 0);
    #1;
    it.efp = nf; it.ecpu = nc; it.ehaz = haz; it.ahaz = hazard; it.tag = tag;
    mf = nf; mc = nc;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, "fp_status", int'(fp_status), int'(it.efp));
      chk(it.tag, "cpu_status", int'(cpu_status), int'(it.ecpu));
      chk(it.tag, "hazard", int'(it.ahaz), int'(it.ehaz));
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "fp_status", int'(fp_status), 0);
    chk("R1", "cpu_status", int'(cpu_status), 0);
    step(0, 8'h00, 0, 1, 6'b011001, 0, 0, "R10 load TF ZF NI");
    step(0, 8'h00, 0, 0, 6'b000000, 0, 1, "R7 overflow event");
    step(1, 8'h01, 0, 0, 6'b000000, 0, 0, "R4 TF to C and TC");
    step(1, 8'h28, 0, 0, 6'b000000, 0, 0, "R3 ZF NF merge");
    step(1, 8'h14, 0, 0, 6'b000000, 0, 0, "R3 ZI NI merge");
    step(1, 8'h80, 0, 0, 6'b000000, 0, 0, "R2 R6 LVF to OV and clear");
    step(1, 8'h02, 0, 0, 6'b000000, 0, 0, "R5 CI only");
    step(0, 8'hff, 0, 0, 6'b000000, 0, 0, "R5 no strobe");
    step(1, 8'h40, 0, 0, 6'b000000, 0, 0, "R2 LUF clear gives OV 0");
    step(1, 8'h40, 0, 0, 6'b000000, 1, 0, "R7 set beats clear");
    step(1, 8'h40, 0, 0, 6'b000000, 0, 1, "R2 R6 LUF read and clear");
    step(1, 8'h09, 0, 1, 6'b110110, 0, 0, "R10 R8 load with transfer");
    step(0, 8'h00, 1, 0, 6'b000000, 1, 0, "R9 issue two cycle op");
    step(1, 8'hff, 0, 0, 6'b000000, 0, 0, "R9 slot one refused");
    step(1, 8'hff, 0, 0, 6'b000000, 0, 0, "R9 slot two refused");
    step(1, 8'hff, 0, 0, 6'b000000, 0, 0, "R8 R6 first cycle after window");
    step(1, 8'h3d, 0, 1, 6'b000000, 0, 0, "R5 R3 full pairs");
    step(1, 8'h01, 0, 0, 6'b000000, 0, 0, "R4 TF zero");
    step(0, 8'h00, 0, 0, 6'b000000, 0, 0, "idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule